// File: doc/BRIEF.md
# Synchronized Two-Digit Lamp-Number Display

This block keeps a two-digit decimal count of the lamp currently under test and drives two seven-segment digits showing 0 to 63. The count follows a separate 6-bit binary scanner. Both advance on the same minute tick, and both are gated by a run control that starts and stops counting. The scanner signals its wrap with a level. The block turns the rising edge of that level into a one-clock sync pulse, and the pulse clears the decimal count. The two counts therefore cannot drift apart.

The units digit counts 0 to 9 and carries into the tens digit, which counts 0 to 6. Each digit goes through a registered decoder to active-low segment lines in gfedcba order (bit 6 = g, bit 0 = a), suited to common-anode digits. A leading zero in the tens place is blanked. A lamp-test input lights every segment of both digits and overrides the blanking.

Top module: `lampnum_display`

## Requirements
- R1: A synchronous active-high reset sets the count to 00. After reset, the units segments show the digit zero (7'h40) and the tens segments are dark (7'h7F).
- R2: When run and tick are both high at a clock edge, the count rises by one. The units digit goes from 9 to 0 and carries one into the tens digit.
- R3: Counting never leaves 0 to 63. An increment from 63 gives 00. The tens digit is never above 6 and the units digit is never above 9.
- R4: When run is low, tick has no effect and the count holds.
- R5: The count is cleared to 00 at the first clock edge that samples wrap_in high after it was sampled low. While wrap_in stays high, no further clear occurs.
- R6: When a sync clear and an increment fall on the same edge, the clear wins and the count becomes 00.
- R7: One clock after the count changes, each digit's segment output shows that digit. Segments are active-low in gfedcba order: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10 (hex).
- R8: When the tens digit is 0, the tens segments are all off (7'h7F). A units value of 0 is still shown.
- R9: A high lamp_test drives both segment outputs to 7'h00 one clock later, including a tens digit that would otherwise be blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable (start/stop) |
| tick | input | 1 | Minute tick, one clock wide |
| wrap_in | input | 1 | Scanner wrap level |
| lamp_test | input | 1 | Light all segments |
| units_o | output | 4 | BCD units digit |
| tens_o | output | 4 | BCD tens digit |
| seg_units_n | output | 7 | Active-low segments, units, gfedcba |
| seg_tens_n | output | 7 | Active-low segments, tens, gfedcba |

## Verification
The sync clear and a tick increment can arrive on the same edge. The bench provokes this by raising wrap_in in the same cycle as a tick while run is high, at a count well away from zero. The bench's behavioural model gives priority to the clear, so the count must read 00 after that edge and not 01 or one above the old value. Lamp test and leading-zero blanking also coincide: lamp test is asserted while the tens digit is zero, and the tens output must be fully lit rather than dark.

// File: rtl/lampnum_pkg.sv
package lampnum_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;

  // active-high gfedcba pattern of a decimal digit; codes above 9 give dark
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [DIG_W-1:0] d);
    logic [SEG_W-1:0] p;
    case (d)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/lampnum_edge.sv
module lampnum_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign pulse_o = level_i & ~level_q;

  // a held wrap level must not produce a second clear
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R5
endmodule

// File: rtl/lampnum_decade.sv
module lampnum_decade #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         roll,
  output logic [W-1:0] q,
  output logic         at_last
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  assign at_last = (q == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || clr)          q <= '0;
    else if (en) begin
      if (roll || at_last)   q <= '0;
      else                   q <= q + W'(1);
    end
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    q <= LAST_V); // R3
endmodule

// File: rtl/lampnum_segdec.sv
module lampnum_segdec
  import lampnum_pkg::*;
#(
  parameter bit BLANK_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIG_W-1:0] digit,
  input  logic             lamp_test,
  output logic [SEG_W-1:0] seg_n
);
  localparam logic [SEG_W-1:0] DARK_N  = '1;
  localparam logic [SEG_W-1:0] RESET_N = BLANK_ZERO ? DARK_N : ~seg_pattern('0);

  logic             blank;
  logic [SEG_W-1:0] seg_next;

  generate
    if (BLANK_ZERO) begin : g_blank
      assign blank = (digit == '0);
    end else begin : g_noblank
      assign blank = 1'b0;
    end
  endgenerate

  always_comb begin
    if (lamp_test)  seg_next = '0;
    else if (blank) seg_next = DARK_N;
    else            seg_next = ~seg_pattern(digit);
  end

  always_ff @(posedge clk) begin
    if (rst) seg_n <= RESET_N;
    else     seg_n <= seg_next;
  end

  AST_LAMP_TEST_ON: assert property (@(posedge clk) disable iff (rst)
    lamp_test |=> (seg_n == '0)); // R9

  generate
    if (BLANK_ZERO) begin : g_blank_chk
      AST_LEADING_DARK: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test && digit == '0) |=> (seg_n == DARK_N)); // R8
    end
  endgenerate
endmodule

// File: rtl/lampnum_display.sv
module lampnum_display
  import lampnum_pkg::*;
#(
  parameter int TOP_COUNT = 63,
  parameter int RADIX     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap_in,
  input  logic             lamp_test,
  output logic [DIG_W-1:0] units_o,
  output logic [DIG_W-1:0] tens_o,
  output logic [SEG_W-1:0] seg_units_n,
  output logic [SEG_W-1:0] seg_tens_n
);
  localparam int TENS_MAX = TOP_COUNT / RADIX;
  localparam int UNIT_TOP = TOP_COUNT % RADIX;
  localparam logic [DIG_W-1:0] TENS_TOP_V = DIG_W'(TENS_MAX);
  localparam logic [DIG_W-1:0] UNIT_TOP_V = DIG_W'(UNIT_TOP);

  logic sync, step, top_hit, units_last, tens_last;

  lampnum_edge u_edge (
    .clk(clk), .rst(rst), .level_i(wrap_in), .pulse_o(sync)
  );

  assign step    = run & tick;
  assign top_hit = (tens_o == TENS_TOP_V) && (units_o == UNIT_TOP_V);

  lampnum_decade #(.W(DIG_W), .LAST(RADIX-1)) u_units (
    .clk(clk), .rst(rst), .clr(sync), .en(step), .roll(top_hit),
    .q(units_o), .at_last(units_last)
  );

  lampnum_decade #(.W(DIG_W), .LAST(TENS_MAX)) u_tens (
    .clk(clk), .rst(rst), .clr(sync), .en(step & (units_last | top_hit)),
    .roll(top_hit), .q(tens_o), .at_last(tens_last)
  );

  lampnum_segdec #(.BLANK_ZERO(1'b0)) u_seg_units (
    .clk(clk), .rst(rst), .digit(units_o), .lamp_test(lamp_test), .seg_n(seg_units_n)
  );

  lampnum_segdec #(.BLANK_ZERO(1'b1)) u_seg_tens (
    .clk(clk), .rst(rst), .digit(tens_o), .lamp_test(lamp_test), .seg_n(seg_tens_n)
  );

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync |=> (units_o == '0 && tens_o == '0)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!sync && !(run && tick)) |=> ($stable(units_o) && $stable(tens_o))); // R4

  AST_TOP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!sync && step && tens_last && units_o == UNIT_TOP_V) |=>
      (units_o == '0 && tens_o == '0)); // R3
endmodule

// File: tb/lampnum_display_tb.sv
module lampnum_display_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, run = 1'b0, tick = 1'b0, wrap_in = 1'b0, lamp_test = 1'b0;
  logic [3:0] units_o, tens_o;
  logic [6:0] seg_units_n, seg_tens_n;

  int tests = 0, fails = 0;
  string tag = "R1";
  int cnt = 0;
  bit wrap_prev = 1'b0;
  bit lt_prev = 1'b0;
  logic [6:0] exp_u = 7'h40, exp_t = 7'h7F;

  always #4 clk = ~clk;

  lampnum_display dut_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .wrap_in(wrap_in),
    .lamp_test(lamp_test), .units_o(units_o), .tens_o(tens_o),
    .seg_units_n(seg_units_n), .seg_tens_n(seg_tens_n)
  );

  function automatic logic [6:0] lit_n(input int d);
    logic [6:0] p;
    case (d)
      0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
      5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07; 8: p = 7'h7F; default: p = 7'h6F;
    endcase
    return ~p;
  endfunction

  // behavioural reference, updated on each edge from stable inputs
  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; wrap_prev = 1'b0; exp_u = 7'h40; exp_t = 7'h7F; lt_prev = 1'b0;
    end else begin
      lt_prev = lamp_test;
      exp_u = lamp_test ? 7'h00 : lit_n(cnt % 10);
      exp_t = lamp_test ? 7'h00 : ((cnt / 10 == 0) ? 7'h7F : lit_n(cnt / 10));
      if (wrap_in && !wrap_prev) cnt = 0;
      else if (run && tick)      cnt = (cnt == 63) ? 0 : cnt + 1;
      wrap_prev = wrap_in;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst || tag == "R1") begin
      check(tag, int'(units_o), cnt % 10, "units");
      check(tag, int'(tens_o), cnt / 10, "tens");
      check(lt_prev ? "R9" : "R7", int'(seg_units_n), int'(exp_u), "seg_units");
      check(lt_prev ? "R9" : ((exp_t == 7'h7F) ? "R8" : "R7"),
            int'(seg_tens_n), int'(exp_t), "seg_tens");
    end
  end

  task automatic cyc(input bit r, input bit t, input bit w, input bit l);
    @(negedge clk);
    #1;
    run = r; tick = t; wrap_in = w; lamp_test = l;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    cyc(0, 0, 0, 0);
    tag = "R2";
    for (int i = 0; i < 30; i++) cyc(1, 1, 0, 0);
    for (int i = 0; i < 12; i++) cyc(1, i % 3 == 0, 0, 0);
    tag = "R4";
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);
    tag = "R3";
    for (int i = 0; i < 50; i++) cyc(1, 1, 0, 0);
    tag = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1);
    cyc(1, 0, 0, 0);
    tag = "R5";
    for (int i = 0; i < 15; i++) cyc(1, 1, 0, 0);
    cyc(1, 0, 1, 0);
    for (int i = 0; i < 14; i++) cyc(1, 1, 1, 0);
    cyc(1, 1, 0, 0);
    tag = "R6";
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0);
    cyc(1, 1, 1, 0);
    cyc(1, 1, 0, 0);
    tag = "R9";
    cyc(1, 0, 1, 1);
    cyc(1, 0, 0, 1);
    cyc(1, 0, 0, 0);
    tag = "R1";
    @(negedge clk); #1; rst = 1'b1;
    cyc(1, 1, 0, 0);
    @(negedge clk); #1; rst = 1'b0;
    tag = "R3";
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 130; i++) cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule